// File: doc/BRIEF.md
# Write-Update Snooping Cache Coherence Controller

This block keeps one private, direct-mapped cache coherent with its peers under an update (broadcast) policy with ownership. A store to a block that other caches also hold is broadcast on the shared bus, and every holder patches its own copy. The last writer owns the block and is responsible for returning it to memory. Memory is written only when an owning line is evicted.

The controller has three ports. The processor port takes one load or store at a time and pulses a completion with the data. The bus master port raises a request, holds a command, address and data until granted, and samples the returned data and the wired shared line in the grant cycle. The snoop port watches transactions issued by other caches. It answers in the same cycle on the shared line, and it also supplies data when it holds a copy that is being read.

Each line is in one of five states: INV (empty), VX (only copy, clean), SCLN (shared, not owner), SDRT (shared, owner) and DRTY (only copy, modified). The request machine has five states: IDLE, LOOK, EVICT, FETCH and BCAST. IDLE moves to LOOK when a request is accepted. LOOK returns to IDLE on a read hit or on a local write, and stays in LOOK while a snoop touches the same set. From LOOK the machine goes to BCAST on a shared write hit, to EVICT when the victim line is owned, and to FETCH on any other miss. EVICT always moves to FETCH. FETCH returns to IDLE, or goes to BCAST after a write miss that another cache served. BCAST always returns to IDLE.

Top module: `wu_snoop_cache_ctrl`

## Requirements
- R1: After reset every line is INV. cpu_done and bus_req are low, and a snoop to any address leaves snp_shared and snp_supply low.
- R2: A read miss issues a READ (bus_cmd 0) for the requested address. If bus_shared_in is low in the grant cycle, the line is filled from bus_rdata as VX and the data is returned.
- R3: A read miss whose grant cycle has bus_shared_in high fills the line as SCLN, so that a later store to it is broadcast.
- R4: A snooped READ that matches a valid line raises snp_shared and snp_supply and drives the line data on snp_rdata in the same cycle. VX and SCLN become SCLN. DRTY and SDRT become SDRT.
- R5: A store that hits a VX or DRTY line completes with no bus transaction and leaves the line DRTY.
- R6: A store that hits an SCLN or SDRT line issues an UPDATE (bus_cmd 1) carrying the address and the new data, held until granted. The line becomes SDRT if bus_shared_in is high at the grant and DRTY if it is low. Completion follows the grant by one cycle.
- R7: A snooped UPDATE that matches a valid line raises snp_shared but not snp_supply. The line takes snp_data and becomes SCLN.
- R8: A store miss issues a READ. If bus_shared_in is high at the grant, the line is written as SDRT and an UPDATE with the new data follows. If it is low, the line is written as DRTY and no broadcast is made.
- R9: A read hit returns the line data with no bus transaction and no change of state.
- R10: When a miss replaces a DRTY or SDRT line, a WRITEBACK (bus_cmd 2) with the victim's address and data precedes the READ. A VX or SCLN victim is dropped with no writeback. The index is address bits [IDX_W-1:0] and the tag is the rest.
- R11: A snoop whose tag does not match a valid line, and any snooped WRITEBACK, leaves snp_shared and snp_supply low and the line unchanged.
- R12: If a snoop addresses the set of the request in LOOK, the lookup waits one cycle and then acts on the state the snoop left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Block address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data (store data on writes) |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 0 READ, 1 UPDATE, 2 WRITEBACK, 3 none |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Update or writeback data |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_rdata | input | DATA_W | Fill data from memory or a peer |
| bus_shared_in | input | 1 | Wired shared line seen in the grant cycle |
| snp_valid | input | 1 | A peer transaction is on the bus |
| snp_cmd | input | 2 | Peer command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Peer address |
| snp_data | input | DATA_W | Peer update data |
| snp_shared | output | 1 | This cache holds the snooped block |
| snp_supply | output | 1 | This cache drives snp_rdata |
| snp_rdata | output | DATA_W | Supplied block data |

## Verification
The processor lookup and a snoop can both touch the same set in one cycle. The bench provokes this with a store to a VX line while a peer's READ for that line is presented during the LOOK cycle. The snoop must supply the old data at once. The store must then see the line as shared and broadcast an UPDATE rather than complete locally. Results are judged at the ports: the scoreboard compares the expected order of bus transactions and completions, and the snoop response is checked directly.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        LN_INV  = 3'd0,
        LN_VX   = 3'd1,
        LN_SCLN = 3'd2,
        LN_SDRT = 3'd3,
        LN_DRTY = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_RD  = 2'd0,
        CMD_UPD = 2'd1,
        CMD_WB  = 2'd2,
        CMD_NOP = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        FS_IDLE  = 3'd0,
        FS_LOOK  = 3'd1,
        FS_EVICT = 3'd2,
        FS_FETCH = 3'd3,
        FS_BCAST = 3'd4
    } fsm_st_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_we,
    input  logic [IDX_W-1:0]  m_idx,
    input  logic [TAG_W-1:0]  m_tag,
    input  line_st_e          m_state,
    input  logic [DATA_W-1:0] m_data,
    input  logic              s_we,
    input  logic [IDX_W-1:0]  s_idx,
    input  line_st_e          s_state,
    input  logic [DATA_W-1:0] s_data,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [TAG_W-1:0]  ra_tag,
    output line_st_e          ra_state,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [TAG_W-1:0]  rb_tag,
    output line_st_e          rb_state,
    output logic [DATA_W-1:0] rb_data
);

    line_st_e          st_q   [SETS];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    for (genvar g = 0; g < SETS; g++) begin : g_set
        localparam logic [IDX_W-1:0] SET_ID = IDX_W'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[g]   <= LN_INV;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (m_we && m_idx == SET_ID) begin
                st_q[g]   <= m_state;
                tag_q[g]  <= m_tag;
                data_q[g] <= m_data;
            end else if (s_we && s_idx == SET_ID) begin
                st_q[g]   <= s_state;
                data_q[g] <= s_data;
            end
        end
    end

    assign ra_tag   = tag_q[ra_idx];
    assign ra_state = st_q[ra_idx];
    assign ra_data  = data_q[ra_idx];
    assign rb_tag   = tag_q[rb_idx];
    assign rb_state = st_q[rb_idx];
    assign rb_data  = data_q[rb_idx];

    // R7
    snoop_data_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_we && !(m_we && m_idx == s_idx)) |=>
        (data_q[$past(s_idx)] == $past(s_data) && st_q[$past(s_idx)] == $past(s_state)));

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_data,
    input  logic [TAG_W-1:0]  rb_tag,
    input  line_st_e          rb_state,
    input  logic [DATA_W-1:0] rb_data,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_rdata,
    output logic              s_we,
    output line_st_e          s_state,
    output logic [DATA_W-1:0] s_data
);

    bus_cmd_e         cmd_e;
    logic [TAG_W-1:0] s_tag;
    logic             s_hit;

    assign cmd_e = bus_cmd_e'(snp_cmd);
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];
    assign s_hit = snp_valid && (rb_state != LN_INV) && (rb_tag == s_tag);

    always_comb begin
        snp_shared = 1'b0;
        snp_supply = 1'b0;
        snp_rdata  = '0;
        s_we       = 1'b0;
        s_state    = rb_state;
        s_data     = rb_data;
        unique case (cmd_e)
            CMD_RD: begin
                if (s_hit) begin
                    snp_shared = 1'b1;
                    snp_supply = 1'b1;
                    snp_rdata  = rb_data;
                    s_we       = 1'b1;
                    s_state    = (rb_state == LN_DRTY || rb_state == LN_SDRT) ? LN_SDRT : LN_SCLN;
                end
            end
            CMD_UPD: begin
                if (s_hit) begin
                    snp_shared = 1'b1;
                    s_we       = 1'b1;
                    s_state    = LN_SCLN;
                    s_data     = snp_data;
                end
            end
            default: begin
            end
        endcase
    end

    // R11
    idle_snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!snp_valid || cmd_e == CMD_WB) |-> (!snp_shared && !snp_supply));

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              snp_valid,
    input  logic [IDX_W-1:0]  snp_idx,
    output logic              bus_req,
    output bus_cmd_e          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared_in,
    output logic [IDX_W-1:0]  ra_idx,
    input  logic [TAG_W-1:0]  ra_tag,
    input  line_st_e          ra_state,
    input  logic [DATA_W-1:0] ra_data,
    output logic              m_we,
    output logic [IDX_W-1:0]  m_idx,
    output logic [TAG_W-1:0]  m_tag,
    output line_st_e          m_state,
    output logic [DATA_W-1:0] m_data
);

    fsm_st_e           cur, nxt;
    logic              req_we;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              hit, clash, done_d;
    logic [DATA_W-1:0] rdata_d;

    assign req_idx = req_addr[IDX_W-1:0];
    assign req_tag = req_addr[ADDR_W-1:IDX_W];
    assign ra_idx  = req_idx;
    assign m_idx   = req_idx;
    assign hit     = (ra_state != LN_INV) && (ra_tag == req_tag);
    assign clash   = snp_valid && (snp_idx == req_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur       <= FS_IDLE;
            req_we    <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            cur       <= nxt;
            cpu_done  <= done_d;
            cpu_rdata <= rdata_d;
            if (cur == FS_IDLE && cpu_req && !cpu_done) begin
                req_we    <= cpu_we;
                req_addr  <= cpu_addr;
                req_wdata <= cpu_wdata;
            end
        end
    end

    always_comb begin
        nxt     = cur;
        m_we    = 1'b0;
        m_tag   = req_tag;
        m_state = LN_INV;
        m_data  = ra_data;
        done_d  = 1'b0;
        rdata_d = cpu_rdata;
        unique case (cur)
            FS_IDLE: begin
                if (cpu_req && !cpu_done) nxt = FS_LOOK;
            end
            FS_LOOK: begin
                if (clash) begin
                    nxt = FS_LOOK;
                end else if (hit && !req_we) begin
                    done_d  = 1'b1;
                    rdata_d = ra_data;
                    nxt     = FS_IDLE;
                end else if (hit && (ra_state == LN_VX || ra_state == LN_DRTY)) begin
                    m_we    = 1'b1;
                    m_state = LN_DRTY;
                    m_data  = req_wdata;
                    done_d  = 1'b1;
                    rdata_d = req_wdata;
                    nxt     = FS_IDLE;
                end else if (hit) begin
                    nxt = FS_BCAST;
                end else if (ra_state == LN_DRTY || ra_state == LN_SDRT) begin
                    nxt = FS_EVICT;
                end else begin
                    nxt = FS_FETCH;
                end
            end
            FS_EVICT: begin
                if (bus_gnt) begin
                    m_we    = 1'b1;
                    m_tag   = ra_tag;
                    m_state = LN_INV;
                    nxt     = FS_FETCH;
                end
            end
            FS_FETCH: begin
                if (bus_gnt) begin
                    m_we = 1'b1;
                    if (!req_we) begin
                        m_state = bus_shared_in ? LN_SCLN : LN_VX;
                        m_data  = bus_rdata;
                        done_d  = 1'b1;
                        rdata_d = bus_rdata;
                        nxt     = FS_IDLE;
                    end else if (bus_shared_in) begin
                        m_state = LN_SDRT;
                        m_data  = req_wdata;
                        nxt     = FS_BCAST;
                    end else begin
                        m_state = LN_DRTY;
                        m_data  = req_wdata;
                        done_d  = 1'b1;
                        rdata_d = req_wdata;
                        nxt     = FS_IDLE;
                    end
                end
            end
            FS_BCAST: begin
                if (bus_gnt) begin
                    m_we    = 1'b1;
                    m_state = bus_shared_in ? LN_SDRT : LN_DRTY;
                    m_data  = req_wdata;
                    done_d  = 1'b1;
                    rdata_d = req_wdata;
                    nxt     = FS_IDLE;
                end
            end
            default: nxt = FS_IDLE;
        endcase
    end

    always_comb begin
        bus_req   = 1'b0;
        bus_cmd   = CMD_NOP;
        bus_addr  = req_addr;
        bus_wdata = '0;
        unique case (cur)
            FS_EVICT: begin
                bus_req   = 1'b1;
                bus_cmd   = CMD_WB;
                bus_addr  = {ra_tag, req_idx};
                bus_wdata = ra_data;
            end
            FS_FETCH: begin
                bus_req = 1'b1;
                bus_cmd = CMD_RD;
            end
            FS_BCAST: begin
                bus_req   = 1'b1;
                bus_cmd   = CMD_UPD;
                bus_wdata = req_wdata;
            end
            default: begin
            end
        endcase
    end

    // R6
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    // R6
    bcast_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == CMD_UPD) |=> cpu_done);

    // R10
    evict_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == CMD_WB) |=> (bus_req && bus_cmd == CMD_RD));

    // R8
    shared_wmiss_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == CMD_RD && req_we && bus_shared_in) |=>
        (bus_req && bus_cmd == CMD_UPD));

endmodule

// File: rtl/wu_snoop_cache_ctrl.sv
module wu_snoop_cache_ctrl
    import coh_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_data,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_rdata
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  ra_idx, m_idx, snp_idx;
    logic [TAG_W-1:0]  ra_tag, rb_tag, m_tag;
    line_st_e          ra_state, rb_state, m_state, s_state;
    logic [DATA_W-1:0] ra_data, rb_data, m_data, s_data;
    logic              m_we, s_we;
    bus_cmd_e          bus_cmd_int;

    assign snp_idx = snp_addr[IDX_W-1:0];
    assign bus_cmd = bus_cmd_int;

    coh_line_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .m_we(m_we), .m_idx(m_idx), .m_tag(m_tag), .m_state(m_state), .m_data(m_data),
        .s_we(s_we), .s_idx(snp_idx), .s_state(s_state), .s_data(s_data),
        .ra_idx(ra_idx), .ra_tag(ra_tag), .ra_state(ra_state), .ra_data(ra_data),
        .rb_idx(snp_idx), .rb_tag(rb_tag), .rb_state(rb_state), .rb_data(rb_data)
    );

    coh_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) snoop_i (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_data(snp_data),
        .rb_tag(rb_tag), .rb_state(rb_state), .rb_data(rb_data),
        .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_rdata(snp_rdata),
        .s_we(s_we), .s_state(s_state), .s_data(s_data)
    );

    coh_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .snp_valid(snp_valid), .snp_idx(snp_idx),
        .bus_req(bus_req), .bus_cmd(bus_cmd_int), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
        .ra_idx(ra_idx), .ra_tag(ra_tag), .ra_state(ra_state), .ra_data(ra_data),
        .m_we(m_we), .m_idx(m_idx), .m_tag(m_tag), .m_state(m_state), .m_data(m_data)
    );

    // R12
    port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_we && s_we && m_idx == snp_idx));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cpu_done && !bus_req));

endmodule

// File: tb/wu_snoop_cache_ctrl_tb_top.sv
`timescale 1ns/1ps
module wu_snoop_cache_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_done;
    logic [15:0] cpu_rdata;
    logic        bus_req;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_gnt = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        bus_shared_in = 1'b0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = 2'd3;
    logic [7:0]  snp_addr = '0;
    logic [15:0] snp_data = '0;
    logic        snp_shared, snp_supply;
    logic [15:0] snp_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic        resp_shared = 1'b0;
    logic [15:0] resp_data = '0;
    logic [15:0] mem [256];
    logic [26:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    wu_snoop_cache_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_data(snp_data),
        .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_rdata(snp_rdata)
    );

    function automatic logic [15:0] mval(input logic [7:0] a);
        return {a ^ 8'h5C, a};
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
        end
    endtask

    task automatic push_bus(input logic [1:0] c, input logic [7:0] a, input logic [15:0] d,
                            input string rq);
        exp_q.push_back({1'b0, c, a, d});
        tag_q.push_back(rq);
    endtask

    task automatic push_done(input logic [15:0] d, input string rq);
        exp_q.push_back({1'b1, 2'b00, 8'h00, d});
        tag_q.push_back(rq);
    endtask

    // monitor, bus arbiter and memory model
    always @(negedge clk) begin
        logic [26:0] e;
        string t;
        if (cpu_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected completion", {16'h0, cpu_rdata}, 32'h0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(e[26] && e[15:0] == cpu_rdata, t, "completion",
                      {15'd0, 1'b1, cpu_rdata}, {15'd0, e[26], e[15:0]});
            end
        end
        if (bus_gnt) begin
            bus_gnt = 1'b0;
            bus_shared_in = 1'b0;
        end else if (bus_req) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected bus transaction",
                      {6'd0, bus_cmd, bus_addr, bus_wdata}, 32'h0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(!e[26] && e[25:24] == bus_cmd && e[23:16] == bus_addr &&
                      (bus_cmd == 2'd0 || e[15:0] == bus_wdata), t, "bus transaction",
                      {5'd0, 1'b0, bus_cmd, bus_addr, bus_wdata}, {5'd0, e});
            end
            if (bus_cmd == 2'd2) mem[bus_addr] = bus_wdata;
            bus_rdata = resp_shared ? resp_data : mem[bus_addr];
            bus_shared_in = resp_shared;
            bus_gnt = 1'b1;
        end
    end

    task automatic wait_done(input string rq);
        int n;
        n = 0;
        while (!cpu_done && n < 300) begin
            @(negedge clk);
            n++;
        end
        cpu_req = 1'b0;
        if (n >= 300) check(1'b0, rq, "completion timeout", 32'h0, 32'h1);
        @(negedge clk);
    endtask

    task automatic cpu_op(input logic we, input logic [7:0] a, input logic [15:0] d,
                          input string rq);
        @(negedge clk);
        cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
        wait_done(rq);
    endtask

    task automatic do_snoop(input logic [1:0] c, input logic [7:0] a, input logic [15:0] d,
                            input logic esh, input logic esup, input logic [15:0] edat,
                            input string rq);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_data = d;
        #2;
        check(snp_shared == esh, rq, "snp_shared", {31'd0, snp_shared}, {31'd0, esh});
        check(snp_supply == esup, rq, "snp_supply", {31'd0, snp_supply}, {31'd0, esup});
        if (esup) check(snp_rdata == edat, rq, "snp_rdata", {16'd0, snp_rdata}, {16'd0, edat});
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd3;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = mval(8'(i));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!cpu_done, "R1", "cpu_done after reset", {31'd0, cpu_done}, 32'd0);
        check(!bus_req, "R1", "bus_req after reset", {31'd0, bus_req}, 32'd0);
        do_snoop(2'd0, 8'h00, 16'h0, 1'b0, 1'b0, 16'h0, "R1");

        // R2: private read miss -> VX; R5: local write
        resp_shared = 1'b0;
        push_bus(2'd0, 8'h04, 16'h0, "R2"); push_done(mval(8'h04), "R2");
        cpu_op(1'b0, 8'h04, 16'h0, "R2");
        push_done(16'h1111, "R5");
        cpu_op(1'b1, 8'h04, 16'h1111, "R5");

        // R4: snooped read of DRTY supplies, becomes SDRT
        do_snoop(2'd0, 8'h04, 16'h0, 1'b1, 1'b1, 16'h1111, "R4");
        // R6: shared write hit broadcasts; shared stays SDRT, then lone -> DRTY
        resp_shared = 1'b1;
        push_bus(2'd1, 8'h04, 16'h2222, "R6"); push_done(16'h2222, "R6");
        cpu_op(1'b1, 8'h04, 16'h2222, "R6");
        resp_shared = 1'b0;
        push_bus(2'd1, 8'h04, 16'h3333, "R6"); push_done(16'h3333, "R6");
        cpu_op(1'b1, 8'h04, 16'h3333, "R6");
        push_done(16'h4444, "R6");
        cpu_op(1'b1, 8'h04, 16'h4444, "R6");
        // R9: read hit
        push_done(16'h4444, "R9");
        cpu_op(1'b0, 8'h04, 16'h0, "R9");
        do_snoop(2'd0, 8'h04, 16'h0, 1'b1, 1'b1, 16'h4444, "R9");

        // R10: owned victim written back, clean victim dropped
        push_bus(2'd2, 8'h04, 16'h4444, "R10"); push_bus(2'd0, 8'h08, 16'h0, "R10");
        push_done(mval(8'h08), "R10");
        cpu_op(1'b0, 8'h08, 16'h0, "R10");
        check(mem[8'h04] == 16'h4444, "R10", "memory after writeback", {16'd0, mem[8'h04]}, 32'h4444);
        push_bus(2'd0, 8'h0C, 16'h0, "R10"); push_done(mval(8'h0C), "R10");
        cpu_op(1'b0, 8'h0C, 16'h0, "R10");

        // R3: shared read miss -> SCLN
        resp_shared = 1'b1; resp_data = 16'h5A5A;
        push_bus(2'd0, 8'h05, 16'h0, "R3"); push_done(16'h5A5A, "R3");
        cpu_op(1'b0, 8'h05, 16'h0, "R3");
        do_snoop(2'd0, 8'h05, 16'h0, 1'b1, 1'b1, 16'h5A5A, "R4");
        push_bus(2'd1, 8'h05, 16'h6006, "R3"); push_done(16'h6006, "R3");
        cpu_op(1'b1, 8'h05, 16'h6006, "R3");

        // R7: snooped update takes data and leaves SCLN
        do_snoop(2'd1, 8'h05, 16'h7777, 1'b1, 1'b0, 16'h0, "R7");
        push_done(16'h7777, "R7");
        cpu_op(1'b0, 8'h05, 16'h0, "R7");
        push_bus(2'd1, 8'h05, 16'h7878, "R7"); push_done(16'h7878, "R7");
        cpu_op(1'b1, 8'h05, 16'h7878, "R7");

        // R8: write miss served by a peer, then by memory
        resp_shared = 1'b1; resp_data = 16'h1234;
        push_bus(2'd0, 8'h06, 16'h0, "R8"); push_bus(2'd1, 8'h06, 16'hBEEF, "R8");
        push_done(16'hBEEF, "R8");
        cpu_op(1'b1, 8'h06, 16'hBEEF, "R8");
        resp_shared = 1'b0;
        push_bus(2'd2, 8'h06, 16'hBEEF, "R8"); push_bus(2'd0, 8'h0A, 16'h0, "R8");
        push_done(16'hCAFE, "R8");
        cpu_op(1'b1, 8'h0A, 16'hCAFE, "R8");
        push_done(16'h0BAD, "R8");
        cpu_op(1'b1, 8'h0A, 16'h0BAD, "R8");

        // R11: non-matching snoop and snooped writeback are ignored
        do_snoop(2'd0, 8'h0E, 16'h0, 1'b0, 1'b0, 16'h0, "R11");
        do_snoop(2'd2, 8'h0A, 16'hFFFF, 1'b0, 1'b0, 16'h0, "R11");
        do_snoop(2'd1, 8'h0E, 16'hFFFF, 1'b0, 1'b0, 16'h0, "R11");
        push_done(16'h0BAD, "R11");
        cpu_op(1'b0, 8'h0A, 16'h0, "R11");

        // R12: snoop read lands in the lookup cycle of a write to a VX line
        resp_shared = 1'b0;
        push_bus(2'd0, 8'h07, 16'h0, "R12"); push_done(mval(8'h07), "R12");
        cpu_op(1'b0, 8'h07, 16'h0, "R12");
        resp_shared = 1'b1;
        push_bus(2'd1, 8'h07, 16'h9999, "R12"); push_done(16'h9999, "R12");
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 8'h07; cpu_wdata = 16'h9999; cpu_req = 1'b1;
        do_snoop(2'd0, 8'h07, 16'h0, 1'b1, 1'b1, mval(8'h07), "R12");
        wait_done("R12");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 32'd0);
        finish_run();
    end

endmodule